// File: doc/BRIEF.md
# Conversion Setup Sequencer

This block runs measurement and calibration commands on behalf of a sigma-delta front end. A small bank of stored setups holds everything a measurement needs: input channel, gain range, polarity, word rate, the two latch-pin levels, the open-circuit current-source enable, a settling-delay flag and a calibration-pair selector. Setups are packed two to a 32-bit register. Registers can be written one at a time or as a burst that fills the whole bank in order.

A command carries a setup pointer and a mode flag, and is accepted only while the block is idle. On acceptance the block copies the chosen setup onto its outputs, latch pins included. If the setup asks for a settling delay, the block waits a fixed number of clocks before it asks the filter to start. The delay length depends on the rate-select configuration input. The filter then reports words. In single mode the block waits for a settled word, signals it once and goes idle. In continuous mode it signals every word, settled or not, until halt is raised.

States: `ST_IDLE` (waits for a command), `ST_LATCH` (one clock after acceptance; setup now on the outputs), `ST_SETTLE` (settling count), `ST_REQ` (start request held towards the filter), `ST_WAIT` (waiting for filter words). Transitions:
- `ST_IDLE` to `ST_LATCH` on an accepted command.
- `ST_LATCH` to `ST_SETTLE` if the delay flag is set, otherwise to `ST_REQ`.
- `ST_SETTLE` to `ST_REQ` when the count expires.
- `ST_REQ` to `ST_WAIT` on acknowledge.
- `ST_WAIT` to `ST_IDLE` on a settled word in single mode.
- Any busy state to `ST_IDLE` on halt in continuous mode.

Top module: `setup_sequencer`

## Requirements
- R1: After reset the block is idle: `busy`, `done` and `meas_req` are 0 and `latch_out`, `chan_sel` and `calreg_sel` are 0.
- R2: A write with `wr_burst`=0 stores `wr_data` in register `wr_idx`. Bits [15:0] become setup 2*`wr_idx` and bits [31:16] become setup 2*`wr_idx`+1. A write with `wr_burst`=1 goes to an internal pointer that starts at register 0 after reset or after any non-burst write, and steps by one register per burst write, so four burst writes fill registers 0 to 3.
- R3: Every setup defaults to all-zero fields. This means channel code 0 (first channel), gain code 0 (1X), bipolar, rate code 0 (the 120 samples/s default), both latch pins 0, current source off, no delay.
- R4: The setup field layout is: [1:0] channel, [4:2] gain, [5] unipolar, [9:6] word rate, [11:10] latch pins, [12] current source, [13] delay, [15:14] calibration pair. When a command is accepted, the selected setup's fields appear on the outputs after the accepting clock edge.
- R5: For a setup without the delay flag, `meas_req` rises one clock after the latch outputs change. With the delay flag, it rises 1280 clocks after them when `cfg_rate_sel` was 0 at acceptance, and 1536 clocks after them when it was 1.
- R6: `calreg_sel` takes the setup's calibration-pair field when `cfg_cal_override` is 1 at acceptance, and the channel field when it is 0.
- R7: In single mode (`cmd_cont`=0), words with `word_settled`=0 produce no `done`. The first settled word produces one `done` pulse and the block returns to idle.
- R8: In continuous mode every word produces a `done` pulse, whether settled or not, and the block stays busy. A `halt` returns it to idle on the next clock, and later words produce no `done`.
- R9: A command presented while busy is ignored, and the setup outputs keep their values.
- R10: `halt` has no effect in single mode.
- R11: `meas_req` stays high until `meas_ack` is seen.
- R12: `done` is a one-clock pulse in the clock after the qualifying word is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low reset |
| cfg_rate_sel | input | 1 | Selects the long settling delay |
| cfg_cal_override | input | 1 | Calibration pair from setup field rather than channel |
| wr_en | input | 1 | Register write strobe |
| wr_burst | input | 1 | Write goes to the burst pointer |
| wr_idx | input | 2 | Register index for single writes |
| wr_data | input | 32 | Two packed setups |
| cmd_valid | input | 1 | Command present |
| cmd_ptr | input | 3 | Setup pointer |
| cmd_cont | input | 1 | 1 = continuous, 0 = single |
| halt | input | 1 | Stops continuous operation |
| meas_req | output | 1 | Start request to the filter |
| meas_ack | input | 1 | Filter accepted the start |
| word_valid | input | 1 | Filter produced a word |
| word_settled | input | 1 | That word is fully settled |
| done | output | 1 | One pulse per delivered word |
| busy | output | 1 | Command in progress |
| latch_out | output | 2 | Latch pin levels |
| chan_sel | output | 2 | Physical channel |
| gain_sel | output | 3 | Gain range code |
| rate_sel | output | 4 | Word rate code |
| unipolar | output | 1 | 1 = unipolar, 0 = bipolar |
| isrc_en | output | 1 | Open-circuit current source enable |
| calreg_sel | output | 2 | Offset/gain register pair |

## Verification
The bench measures the exact clock count from the latch change to the start request, for short, long and absent delays. A design with an off-by-one counter, or one that reads the rate select at the wrong time, misses that count by a clock or by 256. The bench mixes settled and unsettled words in both modes. A design that confuses the modes would end single mode early, or drop words in continuous mode. It also offers commands and halts while busy. A design that accepted them would change the latch pins in the middle of a conversion, or abandon a single conversion. Burst writes followed by a single write show whether the two write paths index and reset the pointer correctly.

// File: rtl/setup_seq_pkg.sv
package setup_seq_pkg;

    typedef struct packed {
        logic [1:0] calsel;
        logic       delay;
        logic       isrc;
        logic [1:0] latch;
        logic [3:0] rate;
        logic       unipolar;
        logic [2:0] gain;
        logic [1:0] chan;
    } setup_t;

    localparam int SETUP_W = $bits(setup_t);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LATCH,
        ST_SETTLE,
        ST_REQ,
        ST_WAIT
    } seq_state_t;

endpackage

// File: rtl/setup_bank.sv
module setup_bank
    import setup_seq_pkg::*;
#(
    parameter int NUM_REGS = 4,
    localparam int IDX_W   = $clog2(NUM_REGS),
    localparam int PTR_W   = IDX_W + 1,
    localparam int WORD_W  = 2 * SETUP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_burst,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [PTR_W-1:0]  rd_ptr,
    output setup_t            rd_setup
);

    logic [IDX_W-1:0]  burst_ptr;
    logic [IDX_W-1:0]  tgt_idx;
    logic [WORD_W-1:0] regs [NUM_REGS];

    assign tgt_idx = wr_burst ? burst_ptr : wr_idx;

    // burst pointer: steps per burst write, rewinds on any single write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            burst_ptr <= '0;
        end else if (wr_en) begin
            if (!wr_burst)
                burst_ptr <= '0;
            else if (burst_ptr == IDX_W'(NUM_REGS - 1))
                burst_ptr <= '0;
            else
                burst_ptr <= burst_ptr + 1'b1;
        end
    end

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                regs[g] <= '0;
            else if (wr_en && tgt_idx == IDX_W'(g))
                regs[g] <= wr_data;
        end
    end

    logic [WORD_W-1:0] sel_word;
    assign sel_word = regs[rd_ptr[PTR_W-1:1]];
    assign rd_setup = rd_ptr[0] ? setup_t'(sel_word[WORD_W-1:SETUP_W])
                                : setup_t'(sel_word[SETUP_W-1:0]);

endmodule

// File: rtl/settle_timer.sv
module settle_timer #(
    parameter int SHORT_CLKS = 1280,
    parameter int LONG_CLKS  = 1536,
    localparam int CNT_W     = $clog2(LONG_CLKS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic long_sel,
    input  logic run,
    output logic expired
);

    logic [CNT_W-1:0] cnt;
    logic             long_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            long_q <= 1'b0;
        end else if (clear) begin
            cnt    <= '0;
            long_q <= long_sel;
        end else if (run) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = long_q ? (cnt == CNT_W'(LONG_CLKS - 1))
                            : (cnt == CNT_W'(SHORT_CLKS - 1));

endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
    import setup_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic       cmd_cont,
    input  logic       halt,
    input  logic       meas_ack,
    input  logic       word_valid,
    input  logic       word_settled,
    input  logic       has_delay,
    input  logic       timer_expired,
    output logic       accept,
    output logic       timer_run,
    output logic       meas_req,
    output logic       busy,
    output logic       done
);

    seq_state_t state, state_nx;
    logic       cont_q;
    logic       stop_now;
    logic       word_ok;

    assign accept   = (state == ST_IDLE) && cmd_valid;
    assign stop_now = halt && cont_q;
    assign word_ok  = word_valid && (cont_q || word_settled);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (cmd_valid) state_nx = ST_LATCH;
            ST_LATCH:  if (stop_now) state_nx = ST_IDLE;
                       else state_nx = has_delay ? ST_SETTLE : ST_REQ;
            ST_SETTLE: if (stop_now) state_nx = ST_IDLE;
                       else if (timer_expired) state_nx = ST_REQ;
            ST_REQ:    if (stop_now) state_nx = ST_IDLE;
                       else if (meas_ack) state_nx = ST_WAIT;
            ST_WAIT:   if (stop_now) state_nx = ST_IDLE;
                       else if (word_ok && !cont_q) state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // registered outputs and mode
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cont_q <= 1'b0;
            done   <= 1'b0;
        end else begin
            if (accept) cont_q <= cmd_cont;
            done <= (state == ST_WAIT) && word_ok && !stop_now;
        end
    end

    assign timer_run = (state == ST_LATCH) || (state == ST_SETTLE);
    assign meas_req  = (state == ST_REQ);
    assign busy      = (state != ST_IDLE);

endmodule

// File: rtl/setup_sequencer.sv
module setup_sequencer
    import setup_seq_pkg::*;
#(
    parameter int NUM_REGS    = 4,
    parameter int SHORT_CLKS  = 1280,
    parameter int LONG_CLKS   = 1536,
    localparam int IDX_W      = $clog2(NUM_REGS),
    localparam int PTR_W      = IDX_W + 1,
    localparam int WORD_W     = 2 * SETUP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_rate_sel,
    input  logic              cfg_cal_override,
    input  logic              wr_en,
    input  logic              wr_burst,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              cmd_valid,
    input  logic [PTR_W-1:0]  cmd_ptr,
    input  logic              cmd_cont,
    input  logic              halt,
    output logic              meas_req,
    input  logic              meas_ack,
    input  logic              word_valid,
    input  logic              word_settled,
    output logic              done,
    output logic              busy,
    output logic [1:0]        latch_out,
    output logic [1:0]        chan_sel,
    output logic [2:0]        gain_sel,
    output logic [3:0]        rate_sel,
    output logic              unipolar,
    output logic              isrc_en,
    output logic [1:0]        calreg_sel
);

    setup_t picked;
    logic   accept;
    logic   timer_run;
    logic   timer_expired;
    logic   delay_q;

    setup_bank #(.NUM_REGS(NUM_REGS)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_burst (wr_burst),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .rd_ptr   (cmd_ptr),
        .rd_setup (picked)
    );

    settle_timer #(.SHORT_CLKS(SHORT_CLKS), .LONG_CLKS(LONG_CLKS)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (accept),
        .long_sel (cfg_rate_sel),
        .run      (timer_run),
        .expired  (timer_expired)
    );

    seq_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .cmd_valid     (cmd_valid),
        .cmd_cont      (cmd_cont),
        .halt          (halt),
        .meas_ack      (meas_ack),
        .word_valid    (word_valid),
        .word_settled  (word_settled),
        .has_delay     (delay_q),
        .timer_expired (timer_expired),
        .accept        (accept),
        .timer_run     (timer_run),
        .meas_req      (meas_req),
        .busy          (busy),
        .done          (done)
    );

    // setup fields captured onto the outputs at acceptance
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_out  <= '0;
            chan_sel   <= '0;
            gain_sel   <= '0;
            rate_sel   <= '0;
            unipolar   <= 1'b0;
            isrc_en    <= 1'b0;
            calreg_sel <= '0;
            delay_q    <= 1'b0;
        end else if (accept) begin
            latch_out  <= picked.latch;
            chan_sel   <= picked.chan;
            gain_sel   <= picked.gain;
            rate_sel   <= picked.rate;
            unipolar   <= picked.unipolar;
            isrc_en    <= picked.isrc;
            calreg_sel <= cfg_cal_override ? picked.calsel : picked.chan;
            delay_q    <= picked.delay;
        end
    end

endmodule

// File: rtl/setup_sequencer_checker.sv
module setup_sequencer_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       halt,
    input logic       meas_req,
    input logic       meas_ack,
    input logic       word_valid,
    input logic       done,
    input logic       busy,
    input logic [1:0] latch_out,
    input logic [1:0] chan_sel
);

    assert_idle_no_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !meas_req);

    assert_req_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_req && !meas_ack && !halt) |=> meas_req);

    assert_done_after_word_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(word_valid));

    assert_done_from_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));

    assert_latch_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(latch_out) && $stable(chan_sel)));

    assert_req_only_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(meas_req) |-> $past(busy));

endmodule

bind setup_sequencer setup_sequencer_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .halt       (halt),
    .meas_req   (meas_req),
    .meas_ack   (meas_ack),
    .word_valid (word_valid),
    .done       (done),
    .busy       (busy),
    .latch_out  (latch_out),
    .chan_sel   (chan_sel)
);

// File: tb/setup_sequencer_test.sv
module setup_sequencer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_rate_sel = 1'b0, cfg_cal_override = 1'b0;
    logic        wr_en = 1'b0, wr_burst = 1'b0;
    logic [1:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic        cmd_valid = 1'b0, cmd_cont = 1'b0, halt = 1'b0;
    logic [2:0]  cmd_ptr = '0;
    logic        meas_ack = 1'b0, word_valid = 1'b0, word_settled = 1'b0;
    logic        meas_req, done, busy, unipolar, isrc_en;
    logic [1:0]  latch_out, chan_sel, calreg_sel;
    logic [2:0]  gain_sel;
    logic [3:0]  rate_sel;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    setup_sequencer uut (
        .clk(clk), .rst_n(rst_n), .cfg_rate_sel(cfg_rate_sel),
        .cfg_cal_override(cfg_cal_override), .wr_en(wr_en), .wr_burst(wr_burst),
        .wr_idx(wr_idx), .wr_data(wr_data), .cmd_valid(cmd_valid),
        .cmd_ptr(cmd_ptr), .cmd_cont(cmd_cont), .halt(halt),
        .meas_req(meas_req), .meas_ack(meas_ack), .word_valid(word_valid),
        .word_settled(word_settled), .done(done), .busy(busy),
        .latch_out(latch_out), .chan_sel(chan_sel), .gain_sel(gain_sel),
        .rate_sel(rate_sel), .unipolar(unipolar), .isrc_en(isrc_en),
        .calreg_sel(calreg_sel)
    );

    // vector table: pointer, rate select, override, latch, channel, cal pair, delay clocks
    localparam int NV = 8;
    localparam int V_PTR [NV] = '{0, 0, 1, 1, 3, 2, 4, 6};
    localparam int V_RS  [NV] = '{0, 0, 0, 1, 1, 0, 0, 0};
    localparam int V_OV  [NV] = '{1, 0, 0, 1, 0, 1, 1, 0};
    localparam int V_LAT [NV] = '{1, 1, 2, 2, 3, 0, 2, 1};
    localparam int V_CH  [NV] = '{2, 2, 1, 1, 3, 0, 3, 1};
    localparam int V_CAL [NV] = '{3, 2, 1, 0, 3, 2, 0, 1};
    localparam int V_DLY [NV] = '{1, 1, 1280, 1536, 1536, 1, 1, 1};

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input bit burst, input int idx, input logic [31:0] d);
        wr_en = 1'b1; wr_burst = burst; wr_idx = 2'(idx); wr_data = d;
        cyc();
        wr_en = 1'b0; wr_burst = 1'b0;
    endtask

    task automatic issue(input int ptr, input bit cont, input bit rs, input bit ov);
        cmd_valid = 1'b1; cmd_ptr = 3'(ptr); cmd_cont = cont;
        cfg_rate_sel = rs; cfg_cal_override = ov;
        cyc();
        cmd_valid = 1'b0;
    endtask

    // counts clocks until meas_req, then acknowledges
    task automatic to_wait(output int n);
        n = 0;
        while (!meas_req && n < 3000) begin
            cyc();
            n++;
        end
        meas_ack = 1'b1;
        cyc();
        meas_ack = 1'b0;
    endtask

    task automatic word(input bit settled);
        word_valid = 1'b1; word_settled = settled;
        cyc();
        word_valid = 1'b0; word_settled = 1'b0;
    endtask

    initial begin
        int n;
        repeat (3) cyc();
        // R1 reset state
        check(!busy && !done && !meas_req, "R1 idle flags", int'({busy, done, meas_req}), 0);
        check(latch_out == 0 && chan_sel == 0 && calreg_sel == 0, "R1 outputs",
              int'({latch_out, chan_sel, calreg_sel}), 0);
        rst_n = 1'b1;
        cyc();

        // R3 default setup before any write
        issue(7, 1'b0, 1'b0, 1'b1);
        check({latch_out, chan_sel, gain_sel, rate_sel, unipolar, isrc_en, calreg_sel} == 0,
              "R3 default fields",
              int'({latch_out, chan_sel, gain_sel, rate_sel, unipolar, isrc_en, calreg_sel}), 0);
        to_wait(n);
        check(n == 1, "R3 default no delay", n, 1);
        word(1'b1);
        check(done && !busy, "R3 done", int'({done, busy}), 2);

        // R2 burst fills registers 0..3, then a single write replaces register 2
        wr(1'b1, 0, 32'h2881_D56E);
        wr(1'b1, 0, 32'h6C03_8000);
        wr(1'b1, 0, 32'h0000_0000);
        wr(1'b1, 0, 32'h0000_0401);
        wr(1'b0, 2, 32'h0000_0803);

        // R4 full field decode on setup 0
        issue(0, 1'b0, 1'b0, 1'b1);
        check(gain_sel == 3 && rate_sel == 5 && unipolar && isrc_en, "R4 fields",
              int'({gain_sel, rate_sel, unipolar, isrc_en}), int'({3'd3, 4'd5, 1'b1, 1'b1}));
        to_wait(n);
        word(1'b1);
        cyc();

        // table walk: R2 R4 R5 R6 R7
        for (int i = 0; i < NV; i++) begin
            issue(V_PTR[i], 1'b0, V_RS[i][0], V_OV[i][0]);
            check(latch_out == 2'(V_LAT[i]), "R4 latch", int'(latch_out), V_LAT[i]);
            check(chan_sel == 2'(V_CH[i]), "R2 channel", int'(chan_sel), V_CH[i]);
            check(calreg_sel == 2'(V_CAL[i]), "R6 cal pair", int'(calreg_sel), V_CAL[i]);
            to_wait(n);
            check(n == V_DLY[i], "R5 delay", n, V_DLY[i]);
            word(1'b0);
            check(!done && busy, "R7 unsettled ignored", int'({done, busy}), 1);
            word(1'b1);
            check(done && !busy, "R7 settled done", int'({done, busy}), 2);
            cyc();
            check(!done, "R12 pulse width", int'(done), 0);
        end

        // R11 request held without acknowledge; R10 halt ignored in single mode
        issue(0, 1'b0, 1'b0, 1'b0);
        repeat (5) cyc();
        check(meas_req, "R11 request held", int'(meas_req), 1);
        meas_ack = 1'b1; cyc(); meas_ack = 1'b0;
        halt = 1'b1; cyc(); halt = 1'b0;
        check(busy, "R10 halt ignored", int'(busy), 1);
        word(1'b1);
        check(done, "R10 done after halt", int'(done), 1);
        cyc();

        // R8 continuous mode, R9 command while busy
        issue(2, 1'b1, 1'b0, 1'b0);
        to_wait(n);
        for (int k = 0; k < 3; k++) begin
            word(k == 2);
            check(done && busy, "R8 every word", int'({done, busy}), 3);
        end
        issue(0, 1'b0, 1'b0, 1'b1);
        check(latch_out == 0 && chan_sel == 0 && calreg_sel == 0, "R9 command ignored",
              int'({latch_out, chan_sel, calreg_sel}), 0);
        halt = 1'b1; cyc(); halt = 1'b0;
        check(!busy, "R8 halt to idle", int'(busy), 0);
        word(1'b1);
        check(!done, "R8 no done after halt", int'(done), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule